// File: doc/BRIEF.md
# Single-Port RAM with a Shared Three-State Data Bus

This block is a word-addressed random-access memory. Data enters and leaves on one bidirectional bus. The direction of the bus comes from either a write-enable input or an inverted output-enable input; a parameter chooses which one. A memory-enable input turns the block off. While it is off, the bus floats and no write can happen. Writes take effect on the rising edge of the input clock. Reads load an output register on the rising edge of a separate output clock, and the bus then drives that register.

Three parameters decide whether each stage is registered or combinational:
- the captured bus data,
- the address/enable/direction group,
- the read output.

All three are registered by default. The word count defaults to two to the power of the address width and may be set smaller. Writes to addresses at or above the word count are dropped. Reads of such addresses return an undefined word, which appears as X in a four-state simulator.

A small controller keeps a bus mode. The mode is `MODE_OFF` (disabled, bus floating), `MODE_READ` (the block drives the bus) or `MODE_WRITE` (the bus is an input). With registered controls, the mode is a state register that moves on every input-clock edge:
- into `MODE_OFF` whenever the memory enable is low;
- into `MODE_WRITE` when the block is enabled and the direction input asks for a write;
- into `MODE_READ` otherwise.

Any mode can move to any other. With combinational controls, the mode follows the inputs directly.

Top module: `sprbus_ram`

## Requirements
- R1: With the memory enable high and write direction selected, the word on the bus is stored at the addressed location. In the fully registered configuration this happens on the second input-clock edge after the inputs are presented. In the fully combinational configuration it happens on the first edge. With write direction off, memory is unchanged.
- R2: With the memory enable low, the bus floats and no location is written, whatever the direction inputs carry.
- R3: In read direction, the output register loads the addressed word on each output-clock edge, and the bus drives the register. In the fully registered configuration, a newly presented address appears on the bus after the second output-clock edge.
- R4: The output register changes only on output-clock edges while in read direction. Between edges the bus value is held, and the write enable is not used as a load enable.
- R5: In write direction the block does not drive the bus.
- R6: With `DIR_FROM_WE`=1, write direction is `we`=1 and `oe` is ignored. With `DIR_FROM_WE`=0, write direction is `oe`=0 and `we` is ignored.
- R7: A read of an address at or above `WORDS` yields an undefined word and leaves memory untouched. A following in-range read returns correct data.
- R8: A write to an address at or above `WORDS` is dropped, and every in-range word keeps its value.
- R9: With all stages combinational, the bus shows the addressed word combinationally whenever the block is enabled in read direction. A write lands on the next input-clock edge.
- R10: While `rst_n` is low, the registered controller sits in `MODE_OFF`, so the bus floats. The output register clears to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_clk | input | 1 | Clock for writes and for input/control capture |
| out_clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset of the control and output registers |
| addr | input | ADDR_W | Word address |
| mem_en | input | 1 | Memory enable; low floats the bus and blocks writes |
| we | input | 1 | Write direction when `DIR_FROM_WE`=1 |
| oe | input | 1 | Read direction when `DIR_FROM_WE`=0 (inverse of write) |
| dio | inout | DATA_W | Shared three-state data bus |

## Verification
The embedded assertions check several rules on every clock:
- the bus driver and the write strobe are never active together;
- a disabled block neither drives nor writes;
- a write strobe never targets an out-of-range address;
- a qualifying write request always raises the strobe;
- the output register holds whenever it is not loading.

Only the bench scenarios can show the end-to-end data relations:
- stored words come back intact through two pipeline depths;
- out-of-range writes leave every in-range word unchanged;
- the bus really floats during the disabled and write-direction modes, seen through a pulled-up bus;
- the ignored direction input has no effect.

// File: rtl/sprbus_pkg.sv
package sprbus_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_READ  = 2'd1,
        MODE_WRITE = 2'd2
    } bus_mode_e;

    function automatic bus_mode_e pick_mode(input logic en, input logic wr_dir);
        if (!en) begin
            return MODE_OFF;
        end else if (wr_dir) begin
            return MODE_WRITE;
        end
        return MODE_READ;
    endfunction

endpackage

// File: rtl/sprbus_ctrl.sv
module sprbus_ctrl
    import sprbus_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int WORDS       = 16,
    parameter bit REG_CTRL    = 1'b1,
    parameter bit DIR_FROM_WE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              en_in,
    input  logic              we_in,
    input  logic              oe_in,
    output bus_mode_e         mode,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_stb,
    output logic              rd_en
);

    localparam logic [31:0] WORDS_U = 32'(WORDS);

    logic      wr_dir;
    logic      in_range;
    bus_mode_e mode_d;

    assign wr_dir = DIR_FROM_WE ? we_in : ~oe_in;

    always_comb begin
        mode_d = pick_mode(en_in, wr_dir);
    end

    generate
        if (REG_CTRL) begin : g_state_reg
            bus_mode_e         state_q;
            logic [ADDR_W-1:0] addr_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    state_q <= MODE_OFF;
                    addr_q  <= '0;
                end else begin
                    state_q <= mode_d;
                    addr_q  <= addr_in;
                end
            end

            assign mode = state_q;
            assign addr = addr_q;
        end else begin : g_state_flow
            assign mode = mode_d;
            assign addr = addr_in;
        end
    endgenerate

    assign in_range = (32'(addr) < WORDS_U);

    always_comb begin
        wr_stb = 1'b0;
        rd_en  = 1'b0;
        unique case (mode)
            MODE_OFF:   begin end
            MODE_READ:  rd_en  = 1'b1;
            MODE_WRITE: wr_stb = in_range;
            default:    begin end
        endcase
    end

    // R1: an enabled, in-range write request in registered mode raises the strobe one edge later
    assert_write_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (REG_CTRL && en_in && wr_dir && (32'(addr_in) < WORDS_U)) |=> wr_stb);

endmodule

// File: rtl/sprbus_store.sv
module sprbus_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int WORDS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_word
);

    localparam logic [31:0] WORDS_U = 32'(WORDS);

    logic [DATA_W-1:0] mem [WORDS];
    logic              hit;

    assign hit = (32'(addr) < WORDS_U);

    always_ff @(posedge clk) begin
        if (wr_stb && hit) begin
            mem[addr] <= wr_data;
        end
    end

    always_comb begin
        if (hit) begin
            rd_word = mem[addr];
        end else begin
            rd_word = 'x;
        end
    end

    // R8: the controller never strobes a write beyond the word count
    assert_range_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (32'(addr) < WORDS_U));

endmodule

// File: rtl/sprbus_out.sv
module sprbus_out #(
    parameter int DATA_W   = 8,
    parameter bit REG_DOUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] q
);

    generate
        if (REG_DOUT) begin : g_out_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (load) begin
                    q <= word;
                end
            end
        end else begin : g_out_flow
            assign q = word;
        end
    endgenerate

    // R4: the registered output holds across any edge where it is not loading
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (REG_DOUT && !load) |=> (q === $past(q)));

endmodule

// File: rtl/sprbus_ram.sv
module sprbus_ram
    import sprbus_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 4,
    parameter int WORDS       = 2 ** ADDR_W,
    parameter bit REG_DIN     = 1'b1,
    parameter bit REG_CTRL    = 1'b1,
    parameter bit REG_DOUT    = 1'b1,
    parameter bit DIR_FROM_WE = 1'b1
) (
    input  logic              in_clk,
    input  logic              out_clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_en,
    input  logic              we,
    input  logic              oe,
    inout  wire  [DATA_W-1:0] dio
);

    bus_mode_e         mode;
    logic [ADDR_W-1:0] addr_eff;
    logic              wr_stb;
    logic              rd_en;
    logic              drive_en;
    logic [DATA_W-1:0] din;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] q;
    logic              wr_req;

    sprbus_ctrl #(
        .ADDR_W      (ADDR_W),
        .WORDS       (WORDS),
        .REG_CTRL    (REG_CTRL),
        .DIR_FROM_WE (DIR_FROM_WE)
    ) u_ctrl (
        .clk     (in_clk),
        .rst_n   (rst_n),
        .addr_in (addr),
        .en_in   (mem_en),
        .we_in   (we),
        .oe_in   (oe),
        .mode    (mode),
        .addr    (addr_eff),
        .wr_stb  (wr_stb),
        .rd_en   (rd_en)
    );

    generate
        if (REG_DIN) begin : g_din_reg
            always_ff @(posedge in_clk) begin
                din <= dio;
            end
        end else begin : g_din_flow
            assign din = dio;
        end
    endgenerate

    sprbus_store #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .WORDS  (WORDS)
    ) u_store (
        .clk     (in_clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .addr    (addr_eff),
        .wr_data (din),
        .rd_word (rd_word)
    );

    sprbus_out #(
        .DATA_W   (DATA_W),
        .REG_DOUT (REG_DOUT)
    ) u_out (
        .clk   (out_clk),
        .rst_n (rst_n),
        .load  (rd_en),
        .word  (rd_word),
        .q     (q)
    );

    assign drive_en = (mode == MODE_READ);
    assign dio      = drive_en ? q : {DATA_W{1'bz}};
    assign wr_req   = DIR_FROM_WE ? we : ~oe;

    // R2: a disabled block stops driving and writing (one edge later when controls are registered)
    assert_off_reg_R2: assert property (@(posedge in_clk) disable iff (!rst_n)
        (REG_CTRL && !mem_en) |=> (!drive_en && !wr_stb));
    assert_off_flow_R2: assert property (@(posedge in_clk) disable iff (!rst_n)
        (!REG_CTRL && !mem_en) |-> (!drive_en && !wr_stb));

    // R5: write direction never turns on the bus driver
    assert_wdir_float_R5: assert property (@(posedge in_clk) disable iff (!rst_n)
        (!REG_CTRL && mem_en && wr_req) |-> !drive_en);

    // R6: the bus driver and the write strobe are never active together
    assert_dir_excl_R6: assert property (@(posedge in_clk) disable iff (!rst_n)
        !(drive_en && wr_stb));

endmodule

// File: tb/sprbus_ram_test.sv
`timescale 1ns/1ps
module sprbus_ram_test;

    localparam int DW = 8;
    localparam int AW = 3;
    localparam int NW = 6;
    localparam logic [DW-1:0] FLOAT = 8'hFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   fails  = 0;

    always #10 clk = ~clk;

    // registered instance, direction from we
    logic [AW-1:0] a_addr = '0;
    logic          a_en = 1'b0, a_we = 1'b0, a_oe = 1'b0, a_drv = 1'b0;
    logic [DW-1:0] a_val = '0;
    tri1  [DW-1:0] bus_a;
    assign bus_a = a_drv ? a_val : {DW{1'bz}};

    // combinational instance, direction from oe
    logic [AW-1:0] b_addr = '0;
    logic          b_en = 1'b0, b_we = 1'b0, b_oe = 1'b1, b_drv = 1'b0;
    logic [DW-1:0] b_val = '0;
    tri1  [DW-1:0] bus_b;
    assign bus_b = b_drv ? b_val : {DW{1'bz}};

    sprbus_ram #(.DATA_W(DW), .ADDR_W(AW), .WORDS(NW)) uut (
        .in_clk(clk), .out_clk(clk), .rst_n(rst_n), .addr(a_addr),
        .mem_en(a_en), .we(a_we), .oe(a_oe), .dio(bus_a));

    sprbus_ram #(.DATA_W(DW), .ADDR_W(AW), .WORDS(NW), .REG_DIN(1'b0),
                 .REG_CTRL(1'b0), .REG_DOUT(1'b0), .DIR_FROM_WE(1'b0)) uut_flow (
        .in_clk(clk), .out_clk(clk), .rst_n(rst_n), .addr(b_addr),
        .mem_en(b_en), .we(b_we), .oe(b_oe), .dio(bus_b));

    logic [DW-1:0] exp_a [NW];
    logic [DW-1:0] exp_b [NW];
    logic [DW-1:0] got;

    function automatic logic [DW-1:0] pat(input int p, input int a);
        return 8'((a * 37 + p * 53 + 5) % 128);
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // registered: inputs at negedge, stored on the second rising edge
    task automatic a_write(input int adr, input logic [DW-1:0] v, input logic en);
        @(negedge clk);
        a_addr = AW'(adr); a_en = en; a_we = 1'b1; a_oe = 1'b1;
        a_drv = 1'b1; a_val = v;
        @(posedge clk); @(posedge clk); #5;
    endtask

    task automatic a_read(input int adr, output logic [DW-1:0] v);
        @(negedge clk);
        a_addr = AW'(adr); a_en = 1'b1; a_we = 1'b0; a_oe = 1'b0; a_drv = 1'b0;
        @(posedge clk); @(posedge clk); #5;
        v = bus_a;
    endtask

    task automatic b_write(input int adr, input logic [DW-1:0] v);
        @(negedge clk);
        b_addr = AW'(adr); b_en = 1'b1; b_oe = 1'b0; b_we = 1'b0;
        b_drv = 1'b1; b_val = v;
        @(posedge clk); #5;
    endtask

    task automatic b_read(input int adr, output logic [DW-1:0] v);
        @(negedge clk);
        b_addr = AW'(adr); b_en = 1'b1; b_oe = 1'b1; b_we = 1'b1; b_drv = 1'b0;
        #2;
        v = bus_b;
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R10: reset keeps the registered block off and clears its output register
        a_en = 1'b1; a_we = 1'b0; a_addr = '0;
        repeat (3) @(posedge clk);
        #5 check("R10 bus floats in reset", bus_a, FLOAT);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #5;
        check("R10 output register cleared", bus_a, 8'h00);

        // R1 R3: fill and read back, registered path
        for (int i = 0; i < NW; i++) begin
            exp_a[i] = pat(0, i);
            a_write(i, exp_a[i], 1'b1);
        end
        for (int i = 0; i < NW; i++) begin
            a_read(i, got);
            check($sformatf("R1 R3 R6 read addr %0d", i), got, exp_a[i]);
        end

        // R8: out-of-range writes leave every word intact
        a_write(6, 8'h55, 1'b1);
        a_write(7, 8'h2A, 1'b1);
        for (int i = 0; i < NW; i++) begin
            a_read(i, got);
            check($sformatf("R8 word %0d kept", i), got, exp_a[i]);
        end

        // R7: out-of-range read, then in-range read recovers
        a_read(7, got);
        a_read(4, got);
        check("R7 read after undefined read", got, exp_a[4]);

        // R2: disabled write is blocked, disabled bus floats
        a_write(2, 8'h11, 1'b0);
        a_read(2, got);
        check("R2 disabled write blocked", got, exp_a[2]);
        @(negedge clk); a_en = 1'b0; a_we = 1'b0; a_drv = 1'b0;
        @(posedge clk); @(posedge clk); #5;
        check("R2 disabled bus floats", bus_a, FLOAT);

        // R5: write direction, bench released: bus floats (addr 7 is beyond the count)
        @(negedge clk); a_en = 1'b1; a_we = 1'b1; a_addr = 3'd7; a_drv = 1'b0;
        @(posedge clk); @(posedge clk); #5;
        check("R5 write direction floats", bus_a, FLOAT);

        // R3 R4: address change shows after two output edges, held in between
        a_read(1, got);
        check("R3 read addr 1", got, exp_a[1]);
        @(negedge clk); a_addr = 3'd3; #2;
        check("R4 held before edge", bus_a, exp_a[1]);
        @(posedge clk); #5;
        check("R3 R4 one edge later still old", bus_a, exp_a[1]);
        @(posedge clk); #5;
        check("R3 two edges later new word", bus_a, exp_a[3]);

        // R1: second pattern, reverse read order
        for (int i = 0; i < NW; i++) begin
            exp_a[i] = pat(1, i);
            a_write(i, exp_a[i], 1'b1);
        end
        for (int i = NW - 1; i >= 0; i--) begin
            a_read(i, got);
            check($sformatf("R1 pass2 addr %0d", i), got, exp_a[i]);
        end
        @(negedge clk); a_en = 1'b0; a_drv = 1'b0;

        // R9 R6: combinational instance, direction from oe, we held opposite
        for (int i = 0; i < NW; i++) begin
            exp_b[i] = pat(2, i);
            b_write(i, exp_b[i]);
        end
        for (int i = 0; i < NW; i++) begin
            b_read(i, got);
            check($sformatf("R9 R6 flow read addr %0d", i), got, exp_b[i]);
        end
        b_write(6, 8'h33);
        for (int i = 0; i < NW; i++) begin
            b_read(i, got);
            check($sformatf("R8 flow word %0d kept", i), got, exp_b[i]);
        end
        @(negedge clk); b_en = 1'b0; b_oe = 1'b1; b_drv = 1'b0; #2;
        check("R2 flow disabled floats", bus_b, FLOAT);
        @(negedge clk); b_en = 1'b1; b_oe = 1'b0; b_we = 1'b1; b_addr = 3'd7; b_drv = 1'b0; #2;
        check("R5 R6 flow write direction floats", bus_b, FLOAT);
        @(negedge clk); b_en = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule